// File: doc/BRIEF.md
# Tamper Security State Monitor

This block keeps the security state of a battery-backed timekeeping domain. Two independent flags describe that state. The non-valid flag says that the domain lost battery power and has not been set up again. The violation flag says that an armed tamper or overflow event has occurred. Ten event inputs (voltage, clock, temperature, security alarm, external boot, external pins A and B, wire mesh, time overflow, monotonic overflow) are each gated by an enable in the configuration register. Any armed event latches its own detect bit and the violation flag. While either flag is set, or while the time counter is not enabled, the block holds its counter-stop output active.

Software drives the block through a single write port. The write select chooses one of four targets: the configuration register, the control register, the status register (written one-to-clear), or the seconds value of the time counter. The control register has lock bits that can only be set. The soft locks fall away on a system reset. The hard locks fall away only on a battery reset. Leaving the failure condition takes a fixed order of steps: disarm the sources, clear the detect bits, clear the violation flag, and clear the non-valid flag last. The violation flag can only be cleared while the non-valid flag is set. A system reset taken during a violation sets the non-valid flag, unless the failure hard lock is set.

Both resets are synchronous and active low, and the battery reset wins. The block has no streaming data path: every pin is a plain control or status signal, with no valid/ready handshake.

Top module: `tamper_state_monitor`

## Requirements
- R1: While bat_rst_n is low, the next edge sets status_o to 32'h2 (non-valid bit 1 set, everything else clear), and clears ctrl_o, cfg_o and time_o.
- R2: Event input k (0 voltage, 1 clock, 2 temperature, 3 security alarm, 4 external boot, 5 external A, 6 external B, 7 wire mesh, 8 time overflow, 9 monotonic overflow) is armed by cfg bit k. When it is high and armed, the next edge sets status bit 16+k for k<8, bit 2 for k=8, bit 3 for k=9, and the violation flag (status bit 0). An unarmed input changes nothing.
- R3: A write with wr_sel=0 loads cfg_o from wr_data[9:0], except while ctrl bit 29 (configuration soft lock) or ctrl bit 30 (configuration hard lock) is set. In that case the write is ignored.
- R4: A write with wr_sel=3 loads time_o, except while ctrl bit 17 (timer soft lock) or ctrl bit 18 (timer hard lock) is set. In that case the write is ignored.
- R5: A write with wr_sel=1 can set but never clear ctrl bits 30, 29, 18, 17 and 16 (failure hard lock). It loads ctrl bit 3 (time enable) directly. All other ctrl bits stay 0.
- R6: In a cycle with sys_rst_n low (and bat_rst_n high), the next edge clears ctrl bits 29 and 17. It keeps ctrl bits 30, 18, 16 and 3, cfg_o, time_o and the detect bits. Writes and event inputs in that cycle are ignored.
- R7: A system reset taken while the violation flag is set also sets the non-valid flag, unless ctrl bit 16 is set.
- R8: A wr_sel=2 write clears each detect bit written with 1. An armed input that is high in the same cycle keeps its bit set.
- R9: Writing 1 to status bit 0 clears the violation flag only if, before the write, the non-valid flag was set and no detect bit with its enable set was active.
- R10: Writing 1 to status bit 1 clears the non-valid flag only if the violation flag was clear before the write.
- R11: counter_stop_o is high exactly when status bit 0 or bit 1 is set, or ctrl bit 3 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| bat_rst_n | input | 1 | Battery power-on reset, synchronous, active low |
| sys_rst_n | input | 1 | System power-on reset, synchronous, active low |
| evt_i | input | 10 | Event inputs, index as in R2 |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 configuration, 1 control, 2 status (write one to clear), 3 time |
| wr_data | input | 32 | Write data |
| status_o | output | 32 | Status register |
| ctrl_o | output | 32 | Control register |
| cfg_o | output | 10 | Event enable register |
| time_o | output | 32 | Time counter seconds value |
| counter_stop_o | output | 1 | Holds the time counter stopped |

## Verification
The bench goes after the ordering rules of recovery. If the design clears the violation flag while the non-valid flag is low, or while an armed detect bit is still set, the unit leaves failure without a power cycle. If it clears the non-valid flag before the violation flag, the counter restarts while tamper evidence is still present. It also drives a detect-bit clear in the same cycle as a still-active event: a design where the clear wins loses the evidence. Lock handling is probed across system resets. A design that drops a hard lock or keeps a soft lock would either accept a configuration or time write it must ignore, or ignore one it must accept. A system reset during a violation is tried with and without the failure hard lock, to catch a design that enters or skips the non-valid state wrongly.

// File: rtl/tsm_pkg.sv
package tsm_pkg;
  localparam int NSRC = 10;
  localparam int DW   = 32;

  localparam int S_SVF = 0;
  localparam int S_NV  = 1;

  localparam int C_TCE = 3;
  localparam int C_FHL = 16;
  localparam int C_TSL = 17;
  localparam int C_THL = 18;
  localparam int C_CSL = 29;
  localparam int C_CHL = 30;

  typedef enum logic [1:0] {
    SEL_CFG  = 2'd0,
    SEL_CTL  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_TIME = 2'd3
  } wr_sel_e;

  // status bit that latches event k
  function automatic int det_pos(input int k);
    return (k < 8) ? 16 + k : k - 6;
  endfunction

  function automatic logic [DW-1:0] det_mask();
    logic [DW-1:0] m;
    m = '0;
    for (int k = 0; k < NSRC; k++) m[det_pos(k)] = 1'b1;
    return m;
  endfunction

  localparam logic [DW-1:0] STICKY_M = (DW'(1) << C_FHL) | (DW'(1) << C_TSL) |
                                       (DW'(1) << C_THL) | (DW'(1) << C_CSL) |
                                       (DW'(1) << C_CHL);
  localparam logic [DW-1:0] TCE_M = DW'(1) << C_TCE;
endpackage

// File: rtl/tsm_detect.sv
module tsm_detect
  import tsm_pkg::*;
(
  input  logic            active,
  input  logic [NSRC-1:0] evt_i,
  input  logic [NSRC-1:0] en_i,
  input  logic [DW-1:0]   st_i,
  output logic [DW-1:0]   set_o,
  output logic            pend_o
);
  logic [NSRC-1:0] armed;

  generate
    for (genvar k = 0; k < NSRC; k++) begin : g_src
      localparam int P = det_pos(k);
      assign armed[k] = st_i[P] & en_i[k];
    end
  endgenerate

  always_comb begin
    set_o = '0;
    for (int k = 0; k < NSRC; k++)
      set_o[det_pos(k)] = active & evt_i[k] & en_i[k];
  end

  assign pend_o = |armed;
endmodule

// File: rtl/tsm_cfg_regs.sv
module tsm_cfg_regs
  import tsm_pkg::*;
#(
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              bat_rst_n,
  input  logic              sys_rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     ctrl_q,
  output logic [NSRC-1:0]   cfg_q,
  output logic [TIME_W-1:0] time_q
);
  logic cfg_locked, time_locked;
  assign cfg_locked  = ctrl_q[C_CSL] | ctrl_q[C_CHL];
  assign time_locked = ctrl_q[C_TSL] | ctrl_q[C_THL];

  always_ff @(posedge clk) begin
    if (!bat_rst_n) begin
      ctrl_q <= '0;
      cfg_q  <= '0;
      time_q <= '0;
    end else if (!sys_rst_n) begin
      ctrl_q[C_TSL] <= 1'b0;
      ctrl_q[C_CSL] <= 1'b0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_CFG:  if (!cfg_locked) cfg_q <= wr_data[NSRC-1:0];
        SEL_CTL:  ctrl_q <= (ctrl_q & STICKY_M) | (wr_data & (STICKY_M | TCE_M));
        SEL_TIME: if (!time_locked) time_q <= wr_data[TIME_W-1:0];
        default: ;
      endcase
    end
  end

  // R3
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!bat_rst_n)
    cfg_locked |=> $stable(cfg_q));
  // R4
  time_lock_chk: assert property (@(posedge clk) disable iff (!bat_rst_n)
    time_locked |=> $stable(time_q));
  // R6
  hard_keep_chk: assert property (@(posedge clk) disable iff (!bat_rst_n)
    (ctrl_q[C_CHL] && ctrl_q[C_THL]) |=> (ctrl_q[C_CHL] && ctrl_q[C_THL]));
endmodule

// File: rtl/tsm_status.sv
module tsm_status
  import tsm_pkg::*;
(
  input  logic          clk,
  input  logic          bat_rst_n,
  input  logic          sys_rst_n,
  input  logic          fail_hlock,
  input  logic          clr_en,
  input  logic [DW-1:0] clr_data,
  input  logic [DW-1:0] set_vec,
  input  logic          pend,
  output logic [DW-1:0] st_q
);
  localparam logic [DW-1:0] DETM = det_mask();
  logic [DW-1:0] nxt;

  always_comb begin
    nxt = st_q;
    if (clr_en) begin
      nxt = nxt & ~(clr_data & DETM);
      if (clr_data[S_SVF] && st_q[S_NV] && !pend) nxt[S_SVF] = 1'b0;
      if (clr_data[S_NV] && !st_q[S_SVF]) nxt[S_NV] = 1'b0;
    end
    nxt = nxt | set_vec;
    if (|set_vec) nxt[S_SVF] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!bat_rst_n) begin
      st_q       <= '0;
      st_q[S_NV] <= 1'b1;
    end else if (!sys_rst_n) begin
      if (st_q[S_SVF] && !fail_hlock) st_q[S_NV] <= 1'b1;
    end else begin
      st_q <= nxt;
    end
  end

  // R9
  svf_clear_chk: assert property (@(posedge clk) disable iff (!bat_rst_n)
    ($fell(st_q[S_SVF]) && $past(bat_rst_n)) |-> $past(st_q[S_NV]));
  // R10
  nv_last_chk: assert property (@(posedge clk) disable iff (!bat_rst_n)
    ($fell(st_q[S_NV]) && $past(bat_rst_n)) |-> !$past(st_q[S_SVF]));
  // R2
  hit_sets_svf_chk: assert property (@(posedge clk) disable iff (!bat_rst_n)
    (|set_vec) |=> st_q[S_SVF]);
endmodule

// File: rtl/tamper_state_monitor.sv
module tamper_state_monitor
  import tsm_pkg::*;
#(
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              bat_rst_n,
  input  logic              sys_rst_n,
  input  logic [NSRC-1:0]   evt_i,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     status_o,
  output logic [DW-1:0]     ctrl_o,
  output logic [NSRC-1:0]   cfg_o,
  output logic [TIME_W-1:0] time_o,
  output logic              counter_stop_o
);
  logic [DW-1:0] set_vec;
  logic          pend;
  logic          active;

  assign active = bat_rst_n & sys_rst_n;

  tsm_detect u_det (
    .active (active),
    .evt_i  (evt_i),
    .en_i   (cfg_o),
    .st_i   (status_o),
    .set_o  (set_vec),
    .pend_o (pend)
  );

  tsm_cfg_regs #(.TIME_W(TIME_W)) u_regs (
    .clk       (clk),
    .bat_rst_n (bat_rst_n),
    .sys_rst_n (sys_rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .ctrl_q    (ctrl_o),
    .cfg_q     (cfg_o),
    .time_q    (time_o)
  );

  tsm_status u_stat (
    .clk        (clk),
    .bat_rst_n  (bat_rst_n),
    .sys_rst_n  (sys_rst_n),
    .fail_hlock (ctrl_o[C_FHL]),
    .clr_en     (wr_en && (wr_sel == SEL_STAT)),
    .clr_data   (wr_data),
    .set_vec    (set_vec),
    .pend       (pend),
    .st_q       (status_o)
  );

  assign counter_stop_o = status_o[S_SVF] | status_o[S_NV] | ~ctrl_o[C_TCE];
endmodule

// File: tb/tamper_state_monitor_tb_top.sv
module tamper_state_monitor_tb_top;
  logic        clk = 1'b0;
  logic        bat_rst_n = 1'b0, sys_rst_n = 1'b1, wr_en = 1'b0;
  logic [9:0]  evt_i = '0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] status_o, ctrl_o, time_o;
  logic [9:0]  cfg_o;
  logic        counter_stop_o;

  int n_chk = 0, n_bad = 0;
  logic [31:0] m_st = 32'h2, m_ctl = '0, m_tim = '0;
  logic [9:0]  m_cfg = '0;

  always #2.5 clk = ~clk;

  tamper_state_monitor dut_i (
    .clk(clk), .bat_rst_n(bat_rst_n), .sys_rst_n(sys_rst_n), .evt_i(evt_i),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .status_o(status_o),
    .ctrl_o(ctrl_o), .cfg_o(cfg_o), .time_o(time_o), .counter_stop_o(counter_stop_o));

  localparam logic [31:0] STK = (32'd1<<16)|(32'd1<<17)|(32'd1<<18)|(32'd1<<29)|(32'd1<<30);

  function automatic int dpos(input int k);
    return (k < 8) ? 16 + k : k - 6;
  endfunction

  function automatic logic [31:0] detm();
    logic [31:0] m;
    m = '0;
    for (int k = 0; k < 10; k++) m[dpos(k)] = 1'b1;
    return m;
  endfunction

  task automatic model_step();
    logic [31:0] setv, nst;
    logic armed;
    if (!bat_rst_n) begin
      m_st = 32'h2; m_ctl = '0; m_cfg = '0; m_tim = '0;
    end else if (!sys_rst_n) begin
      m_ctl[17] = 1'b0; m_ctl[29] = 1'b0;
      if (m_st[0] && !m_ctl[16]) m_st[1] = 1'b1;
    end else begin
      setv = '0; armed = 1'b0;
      for (int k = 0; k < 10; k++) begin
        if (evt_i[k] && m_cfg[k]) setv[dpos(k)] = 1'b1;
        if (m_st[dpos(k)] && m_cfg[k]) armed = 1'b1;
      end
      nst = m_st;
      if (wr_en && wr_sel == 2'd2) begin
        nst = nst & ~(wr_data & detm());
        if (wr_data[0] && m_st[1] && !armed) nst[0] = 1'b0;
        if (wr_data[1] && !m_st[0]) nst[1] = 1'b0;
      end
      nst = nst | setv;
      if (setv != 0) nst[0] = 1'b1;
      if (wr_en && wr_sel == 2'd0 && !(m_ctl[29] | m_ctl[30])) m_cfg = wr_data[9:0];
      if (wr_en && wr_sel == 2'd3 && !(m_ctl[17] | m_ctl[18])) m_tim = wr_data;
      if (wr_en && wr_sel == 2'd1) m_ctl = (m_ctl & STK) | (wr_data & (STK | 32'h8));
      m_st = nst;
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, update model at edge, compare at next negedge
  task automatic cyc(input logic b, input logic s, input logic we, input logic [1:0] sel,
                     input logic [31:0] d, input logic [9:0] ev);
    bat_rst_n = b; sys_rst_n = s; wr_en = we; wr_sel = sel; wr_data = d; evt_i = ev;
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R1 R2 R5 model status", status_o, m_st);
    chk("R3 R5 R6 model ctrl", ctrl_o, m_ctl);
    chk("R3 model cfg", {22'd0, cfg_o}, {22'd0, m_cfg});
    chk("R4 model time", time_o, m_tim);
    chk("R11 model stop", {31'd0, counter_stop_o}, {31'd0, (m_st[0] | m_st[1] | ~m_ctl[3])});
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d, input logic [9:0] ev);
    cyc(1'b1, 1'b1, 1'b1, sel, d, ev);
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    r = $urandom(32'd4242);
    @(negedge clk);
    cyc(0, 1, 0, 0, 0, 0);
    cyc(0, 1, 0, 0, 0, 0);
    chk("R1 status", status_o, 32'h2);
    chk("R1 ctrl", ctrl_o, 0);
    chk("R1 time", time_o, 0);
    chk("R11 stop after reset", {31'd0, counter_stop_o}, 1);
    wr(2'd1, 32'h8, 0);
    chk("R11 stop with nv", {31'd0, counter_stop_o}, 1);
    wr(2'd2, 32'h2, 0);
    chk("R10 nv cleared", status_o, 0);
    chk("R11 stop released", {31'd0, counter_stop_o}, 0);
    wr(2'd0, 32'h081, 0);
    chk("R3 cfg loaded", {22'd0, cfg_o}, 32'h081);
    cyc(1, 1, 0, 0, 0, 10'h002);
    chk("R2 unarmed ignored", status_o, 0);
    cyc(1, 1, 0, 0, 0, 10'h080);
    chk("R2 wire mesh detect", status_o, (32'd1 << 23) | 32'd1);
    chk("R11 stop on violation", {31'd0, counter_stop_o}, 1);
    wr(2'd2, 32'h1, 0);
    chk("R9 svf kept without nv", status_o[0], 1);
    cyc(1, 0, 0, 0, 0, 0);
    chk("R7 sys reset sets nv", status_o[1], 1);
    wr(2'd2, 32'h1, 0);
    chk("R9 svf kept while armed detect", status_o[0], 1);
    wr(2'd2, 32'h2, 0);
    chk("R10 nv kept while svf", status_o[1], 1);
    wr(2'd2, 32'd1 << 23, 10'h080);
    chk("R8 set wins over clear", status_o[23], 1);
    wr(2'd2, 32'd1 << 23, 0);
    chk("R8 detect cleared", status_o[23], 0);
    wr(2'd2, 32'h1, 0);
    chk("R9 svf cleared", status_o[0], 0);
    wr(2'd2, 32'h2, 0);
    chk("R10 nv cleared last", status_o, 0);
    wr(2'd1, (32'd1 << 29) | 32'h8, 0);
    chk("R5 soft lock set", ctrl_o, (32'd1 << 29) | 32'h8);
    wr(2'd0, 32'h3ff, 0);
    chk("R3 locked cfg ignored", {22'd0, cfg_o}, 32'h081);
    wr(2'd1, 32'h0, 0);
    chk("R5 lock sticky", ctrl_o, 32'd1 << 29);
    wr(2'd3, 32'd1234, 0);
    chk("R4 time loaded", time_o, 32'd1234);
    wr(2'd1, 32'd1 << 18, 0);
    wr(2'd3, 32'd99, 0);
    chk("R4 locked time ignored", time_o, 32'd1234);
    wr(2'd1, (32'd1 << 30) | (32'd1 << 16), 0);
    cyc(1, 0, 0, 0, 0, 0);
    chk("R6 soft cleared hard kept", ctrl_o, (32'd1 << 30) | (32'd1 << 18) | (32'd1 << 16));
    chk("R6 cfg kept", {22'd0, cfg_o}, 32'h081);
    chk("R6 time kept", time_o, 32'd1234);
    cyc(1, 1, 0, 0, 0, 10'h001);
    chk("R2 voltage detect", status_o, (32'd1 << 16) | 32'd1);
    cyc(1, 0, 0, 0, 0, 0);
    chk("R7 hard lock blocks nv", status_o[1], 0);
    cyc(0, 1, 0, 0, 0, 0);
    chk("R1 battery reset clears locks", ctrl_o, 0);
    for (int i = 0; i < 4000; i++) begin
      logic b, s, we;
      logic [1:0] sel;
      logic [31:0] d;
      logic [9:0] ev;
      b  = ($urandom_range(0, 599) != 0);
      s  = ($urandom_range(0, 59) != 0);
      we = ($urandom_range(0, 2) != 0);
      sel = 2'($urandom_range(0, 3));
      d = $urandom();
      if (sel == 2'd2 && $urandom_range(0, 1) == 1) d = d & 32'h3;
      if (sel == 2'd1) d = d & ~((32'd1 << 30) | (32'd1 << 18));
      ev = ($urandom_range(0, 7) == 0) ? 10'(1 << $urandom_range(0, 9)) : 10'd0;
      cyc(b, s, we, sel, d, ev);
    end
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule